// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block takes control words for a dual PLL synthesizer from a slow three-wire serial bus (a serial clock, a data line and an active-low load line) and turns them into four parallel divider registers in the system clock domain. While the load line is low, each rising edge of the serial clock shifts one data bit in, most significant bit first. When the load line goes back high, the word is committed.

The two bits that arrive last are the word's two lowest bits. They pick the destination: the reference or main divider register of either PLL. A word whose length is not exactly the configured word width is dropped. All three serial lines are resynchronised into the system clock, and their edges are detected there. Every commit produces a single-cycle update strobe for the register that was written, so downstream divider logic can reload.

Top module: `tw_synth_loader`

## Requirements
- R1: A committed word appears in its destination register with the first bit shifted in at bit 21 and the last bit shifted in at bit 0.
- R2: Exactly one data bit is captured per rising edge of the serial clock while the load line is low. Falling serial clock edges capture nothing.
- R3: Serial clock edges that occur while the load line is high neither shift data nor count bits.
- R4: A low-to-high transition of the load line commits the word. Word bits [1:0] select the destination: 00 PLL2 reference (strobe bit 0), 01 PLL2 main (bit 1), 10 PLL1 reference (bit 2), 11 PLL1 main (bit 3).
- R5: A commit changes only the selected register. The other three keep their values.
- R6: If the load line rises after any number of captured bits other than 22 (for example 21 or 23), no register changes and no strobe is raised.
- R7: Each valid commit raises exactly one bit of the update strobe, the bit matching the select code, for exactly one system clock cycle.
- R8: Synchronous reset clears all four registers, the strobes and the bit counter. A word shifted partly before reset does not count toward the next word.
- R9: In the cycle a strobe bit is high, its register already holds the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Load line: low during entry, rising edge commits |
| pll2_ref_o | output | 22 | PLL2 reference divider register |
| pll2_main_o | output | 22 | PLL2 main divider register |
| pll1_ref_o | output | 22 | PLL1 reference divider register |
| pll1_main_o | output | 22 | PLL1 main divider register |
| upd_stb_o | output | 4 | One-cycle update strobes, indexed by select code |

## Verification
The bench builds the block with its default parameters: a 22-bit word, a 2-bit select field and two synchronizer stages. It holds each serial clock phase and data setup for four system clocks, well above the synchronizer latency. With a 2-bit select, all four destinations are reachable, and every select code is driven both directly and from random words. The bit counter's saturation point at 23 is also reachable, so the short and long discard lengths on either side of 22 can be exercised.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Destination codes carried in the lowest word bits
  typedef enum logic [1:0] {
    DEST_P2_REF  = 2'b00,
    DEST_P2_MAIN = 2'b01,
    DEST_P1_REF  = 2'b10,
    DEST_P1_MAIN = 2'b11
  } dest_e;

  localparam int unsigned DEST_SEL_W = 2;
  localparam int unsigned DEST_COUNT = 1 << DEST_SEL_W;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tw_deser.sv
module tw_deser #(
  parameter int unsigned WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_clk,
  input  logic              s_dat,
  input  logic              s_load,
  output logic              commit_vld,
  output logic [WORD_W-1:0] commit_word
);
  localparam int unsigned CNT_MAX = WORD_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic              clk_q, load_q;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              clk_rise, load_rise, load_fall;

  assign clk_rise  = s_clk & ~clk_q;
  assign load_rise = s_load & ~load_q;
  assign load_fall = ~s_load & load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q       <= 1'b0;
      load_q      <= 1'b0;
      shift_q     <= '0;
      bit_cnt     <= '0;
      commit_vld  <= 1'b0;
      commit_word <= '0;
    end else begin
      clk_q      <= s_clk;
      load_q     <= s_load;
      commit_vld <= 1'b0;
      if (load_rise) begin
        commit_vld  <= (bit_cnt == CNT_W'(WORD_W));
        commit_word <= shift_q;
        bit_cnt     <= '0;
      end else if (load_fall) begin
        bit_cnt <= '0;
      end else if (clk_rise && !s_load) begin
        shift_q <= {shift_q[WORD_W-2:0], s_dat};
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(CNT_MAX)); // R6
  AST_LOAD_HIGH_FREEZES: assert property (@(posedge clk) disable iff (rst)
    s_load |=> $stable(shift_q)); // R3
  AST_COMMIT_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> $past(bit_cnt) == CNT_W'(WORD_W)); // R6
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
  parameter int unsigned WORD_W = 22,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                commit_vld,
  input  logic [WORD_W-1:0]                   commit_word,
  output logic [(1<<SEL_W)-1:0][WORD_W-1:0]   regs_o,
  output logic [(1<<SEL_W)-1:0]               stb_o
);
  localparam int unsigned NUM = 1 << SEL_W;

  logic [SEL_W-1:0] sel;
  assign sel = commit_word[SEL_W-1:0];

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs_o[g] <= '0;
          stb_o[g]  <= 1'b0;
        end else begin
          stb_o[g] <= commit_vld && (sel == SEL_W'(g));
          if (commit_vld && (sel == SEL_W'(g))) regs_o[g] <= commit_word;
        end
      end

      AST_STROBE_MATCHES_SEL: assert property (@(posedge clk) disable iff (rst)
        stb_o[g] |-> regs_o[g][SEL_W-1:0] == SEL_W'(g)); // R4
    end
  endgenerate

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_o)); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|stb_o) |=> (stb_o == '0)); // R7
  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_vld |=> $stable(regs_o)); // R5
endmodule

// File: rtl/tw_synth_loader.sv
module tw_synth_loader #(
  parameter int unsigned WORD_W      = 22,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_load_i,
  output logic [WORD_W-1:0] pll2_ref_o,
  output logic [WORD_W-1:0] pll2_main_o,
  output logic [WORD_W-1:0] pll1_ref_o,
  output logic [WORD_W-1:0] pll1_main_o,
  output logic [3:0]        upd_stb_o
);
  import tw_pkg::*;

  logic [2:0]                            synced;
  logic                                  commit_vld;
  logic [WORD_W-1:0]                     commit_word;
  logic [DEST_COUNT-1:0][WORD_W-1:0]     regs;
  logic [DEST_COUNT-1:0]                 stb;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_load_i, ser_dat_i, ser_clk_i}),
    .sync_o  (synced)
  );

  tw_deser #(.WORD_W(WORD_W)) deser_i (
    .clk         (clk),
    .rst         (rst),
    .s_clk       (synced[0]),
    .s_dat       (synced[1]),
    .s_load      (synced[2]),
    .commit_vld  (commit_vld),
    .commit_word (commit_word)
  );

  tw_regbank #(.WORD_W(WORD_W), .SEL_W(DEST_SEL_W)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .commit_vld  (commit_vld),
    .commit_word (commit_word),
    .regs_o      (regs),
    .stb_o       (stb)
  );

  assign pll2_ref_o  = regs[DEST_P2_REF];
  assign pll2_main_o = regs[DEST_P2_MAIN];
  assign pll1_ref_o  = regs[DEST_P1_REF];
  assign pll1_main_o = regs[DEST_P1_MAIN];
  assign upd_stb_o   = stb;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (upd_stb_o == '0)); // R8
endmodule

// File: tb/tw_synth_loader_tb.sv
module tw_synth_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 22;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b1;
  logic [WW-1:0] p2r, p2m, p1r, p1m;
  logic [3:0] stb;

  int checks = 0;
  int fails = 0;
  logic [WW-1:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_synth_loader dut_i (
    .clk(clk), .rst(rst),
    .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_load_i(ser_load),
    .pll2_ref_o(p2r), .pll2_main_o(p2m), .pll1_ref_o(p1r), .pll1_main_o(p1m),
    .upd_stb_o(stb)
  );

  function automatic logic [WW-1:0] outv(input int i);
    case (i)
      0: return p2r;
      1: return p2m;
      2: return p1r;
      default: return p1m;
    endcase
  endfunction

  function automatic logic [3:0] exp_stb(input logic [WW-1:0] w);
    return 4'b0001 << w[1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    ser_load = 1'b0;
    waitc(HOLD);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      waitc(HOLD);
      ser_clk = 1'b1;
      waitc(HOLD);
      ser_clk = 1'b0;
    end
    waitc(HOLD);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++)
      chk(outv(i) == model[i], req, 32'(outv(i)), 32'(model[i]));
  endtask

  task automatic transfer(input logic [31:0] bits, input int n);
    int cycles = 0;
    logic [3:0] seen = '0;
    logic [WW-1:0] cap = '0;
    int idx;
    shift_bits(bits, n);
    ser_load = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (stb != 4'b0) begin
        cycles++;
        seen = stb;
        for (int i = 0; i < 4; i++) if (stb[i]) cap = outv(i);
      end
    end
    if (n == WW) begin
      idx = int'(bits[1:0]);
      chk(cycles == 1, "R7 strobe width", 32'(cycles), 32'd1);
      chk(seen == exp_stb(bits[WW-1:0]), "R4 R7 strobe select", 32'(seen), 32'(exp_stb(bits[WW-1:0])));
      chk(cap == bits[WW-1:0], "R9 R1 value at strobe", 32'(cap), 32'(bits[WW-1:0]));
      model[idx] = bits[WW-1:0];
      check_all("R5 R1 R2 registers after commit");
    end else begin
      chk(cycles == 0, "R6 discarded word strobe", 32'(cycles), 32'd0);
      check_all("R6 registers unchanged");
    end
    waitc(HOLD);
  endtask

  initial begin
    void'($urandom(32'h1F3A));
    for (int i = 0; i < 4; i++) model[i] = '0;
    waitc(4);
    rst = 1'b0;
    waitc(4);
    chk(stb == 4'b0, "R8 reset strobes", 32'(stb), 32'd0);
    check_all("R8 reset registers");

    // one word per destination, distinctive MSB/LSB patterns
    transfer(32'h200000 | 32'h0, WW);
    transfer(32'h2AAAA9, WW);
    transfer(32'h155556, WW);
    transfer(32'h3FFFFF, WW);

    // wrong lengths
    transfer(32'h12345, WW - 1);
    transfer(32'h7FFFFE, WW + 1);
    transfer(32'h0, 3);

    // R3: serial clock pulses while load is high, then a clean word
    ser_dat = 1'b1;
    for (int k = 0; k < 3; k++) begin
      waitc(HOLD); ser_clk = 1'b1; waitc(HOLD); ser_clk = 1'b0;
    end
    transfer(32'h0F0F0E, WW);
    check_all("R3 edges with load high ignored");

    // R8: reset in the middle of a word
    shift_bits(32'h3FF, 10);
    rst = 1'b1;
    waitc(2);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    waitc(4);
    check_all("R8 mid-word reset clears");
    transfer(32'h1C3C3D, WW);

    // constrained random mix
    for (int r = 0; r < 40; r++) begin
      logic [31:0] w;
      int len;
      w = $urandom();
      len = ($urandom_range(0, 4) == 0) ? ($urandom_range(0, 1) ? WW - 1 : WW + 1) : WW;
      transfer(w & ((32'h1 << len) - 1), len);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule